// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block picks which physical page frame to give up when a new page must be brought in. It keeps a single "recently referenced" flag for each of its frames and a pointer that walks the frames in a ring. Every memory reference reported on the reference inputs marks its frame as recently used. A replacement request starts a search at the pointer. A marked frame is unmarked and skipped, one frame per clock cycle. The search stops at the first frame that is found unmarked. That frame is reported as the victim with a one-cycle completion pulse.

The pointer keeps its position between requests, so each search resumes where the previous one stopped. A frame therefore survives a sweep only if it was referenced since the pointer last passed it. The result approximates least-recently-used replacement with one bit per frame instead of a full recency order. Writing back modified pages, updating translations and loading the new page are the caller's job. The caller only needs the victim index.

Top module: `clock_repl_engine`

## Requirements
- R1: After reset (synchronous, active high) every use flag is clear, the hand is 0, and busy, done and victim are 0. A reset during a search abandons it.
- R2: A cycle with ref_valid high sets the use flag of frame ref_frame at the next clock edge. The flag stays set until a search passes over that frame.
- R3: When idle, a fault_req high at a clock edge starts a search: busy is high from that edge. One frame, the one at the hand, is examined at each following edge.
- R4: An examined frame whose flag is set has the flag cleared and the hand moved forward. The first examined frame whose flag is clear is selected. At that edge done goes high for exactly one cycle, victim takes the frame index and busy falls. From the accepting edge to done there are k+1 edges, where k is the number of frames passed over.
- R5: The hand visits frames in ring order 0,1,…,N-1,0. After a selection it equals (victim+1) mod N. It keeps that value while idle.
- R6: The selected frame's use flag is set at the selecting edge, so the next sweep passes over it once.
- R7: If every flag is set when a search begins, all flags are cleared and the starting frame is selected after N+1 examining edges. A search never stays busy for more than N+1 cycles.
- R8: If a reference targets the frame that the search clears at the same edge, the reference wins and the flag ends up set.
- R9: fault_req while busy is ignored. It neither extends the current search nor starts another one after it.
- R10: References to any frame during a search set that frame's flag, exactly as when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference to frame ref_frame occurs this cycle |
| ref_frame | input | IDX_W (4) | Frame index being referenced |
| fault_req | input | 1 | Request to choose a victim frame |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: victim is valid and fresh |
| victim | output | IDX_W (4) | Index of the frame selected by the last search |
| hand | output | IDX_W (4) | Next frame the hand will examine |

## Verification
The hardest case to reach is a reference that lands on exactly the frame the hand is clearing at that same edge. The stimulus reaches it by marking two frames just ahead of the hand and starting a fault. It then drives a reference to the second frame two cycles later, when the hand is known to be on it. The outcome is made visible at the ports by setting every other flag and faulting again. If the reference won, all flags are set and the full N+1 sweep returns the start frame. If it was lost, the search stops early on that frame. Wrap-around, the all-set sweep and faults issued mid-search are built up from a known flag state by vectors that mark chosen frames before each request.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;

endpackage

// File: rtl/cpr_use_bits.sv
module cpr_use_bits #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_en,
  input  logic [IDX_W-1:0]      ref_idx,
  input  logic                  clr_en,
  input  logic                  mark_en,
  input  logic [IDX_W-1:0]      hand_idx,
  output logic [NUM_FRAMES-1:0] use_vec,
  output logic                  cur_bit
);

  // One flag per frame; a set request overrides a clear in the same cycle.
  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    logic hit_ref;
    logic hit_hand;
    assign hit_ref  = ref_en && (ref_idx == IDX_W'(f));
    assign hit_hand = (hand_idx == IDX_W'(f));

    always_ff @(posedge clk) begin
      if (rst) begin
        use_vec[f] <= 1'b0;
      end else if (hit_ref || (mark_en && hit_hand)) begin
        use_vec[f] <= 1'b1;
      end else if (clr_en && hit_hand) begin
        use_vec[f] <= 1'b0;
      end
    end
  end

  assign cur_bit = use_vec[hand_idx];

endmodule

// File: rtl/cpr_hand.sv
module cpr_hand #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] hand
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hand <= '0;
    end else if (adv) begin
      hand <= (hand == LAST) ? '0 : hand + 1'b1;
    end
  end

endmodule

// File: rtl/cpr_sweep_ctl.sv
module cpr_sweep_ctl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_req,
  input  logic             cur_bit,
  input  logic [IDX_W-1:0] hand,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic             clr_en,
  output logic             mark_en,
  output logic             adv
);
  import cpr_pkg::*;

  scan_state_t state;

  assign busy    = (state == ST_SCAN);
  assign adv     = busy;
  assign clr_en  = busy && cur_bit;
  assign mark_en = busy && !cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      victim <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fault_req) state <= ST_SCAN;
        end
        ST_SCAN: begin
          if (!cur_bit) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            victim <= hand;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clock_repl_engine.sv
module clock_repl_engine #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             fault_req,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic [IDX_W-1:0] hand
);

  logic [NUM_FRAMES-1:0] use_vec;
  logic                  cur_bit;
  logic                  clr_en;
  logic                  mark_en;
  logic                  adv;

  cpr_use_bits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bits (
    .clk      (clk),
    .rst      (rst),
    .ref_en   (ref_valid),
    .ref_idx  (ref_frame),
    .clr_en   (clr_en),
    .mark_en  (mark_en),
    .hand_idx (hand),
    .use_vec  (use_vec),
    .cur_bit  (cur_bit)
  );

  cpr_hand #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .hand (hand)
  );

  cpr_sweep_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .fault_req (fault_req),
    .cur_bit   (cur_bit),
    .hand      (hand),
    .busy      (busy),
    .done      (done),
    .victim    (victim),
    .clr_en    (clr_en),
    .mark_en   (mark_en),
    .adv       (adv)
  );

endmodule

// File: rtl/cpr_checker.sv
module cpr_checker #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ref_valid,
  input logic [IDX_W-1:0]      ref_frame,
  input logic                  fault_req,
  input logic                  busy,
  input logic                  done,
  input logic [IDX_W-1:0]      victim,
  input logic [IDX_W-1:0]      hand,
  input logic [NUM_FRAMES-1:0] use_vec
);

  localparam int CNT_W = $clog2(NUM_FRAMES + 2) + 1;

  logic [CNT_W-1:0] busy_cnt;
  logic [IDX_W-1:0] after_victim;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  assign after_victim = (victim == IDX_W'(NUM_FRAMES - 1)) ? '0 : victim + 1'b1;

  // R2 R8 R10
  ref_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> use_vec[$past(ref_frame)]);

  // R3
  busy_from_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fault_req));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  hand_past_victim_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (hand == after_victim));

  // R5
  hand_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(hand));

  // R6
  victim_marked_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> use_vec[victim]);

  // R7 R9
  sweep_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt <= CNT_W'(NUM_FRAMES)));

endmodule

bind clock_repl_engine cpr_checker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_valid (ref_valid),
  .ref_frame (ref_frame),
  .fault_req (fault_req),
  .busy      (busy),
  .done      (done),
  .victim    (victim),
  .hand      (hand),
  .use_vec   (use_vec)
);

// File: tb/tb_clock_repl_engine.sv
module tb_clock_repl_engine;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;
  localparam int IW         = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_valid = 1'b0;
  logic [IW-1:0] ref_frame = '0;
  logic          fault_req = 1'b0;
  logic          busy;
  logic          done;
  logic [IW-1:0] victim;
  logic [IW-1:0] hand;

  int total = 0;
  int bad   = 0;

  // {mask of frames referenced before the fault, expected victim, expected cycles}
  localparam logic [27:0] VECS [0:7] = '{
    {16'h0000, 4'd0, 8'd2},   // empty ring, start frame chosen
    {16'h0000, 4'd1, 8'd2},   // frame 0 was marked as victim
    {16'h001C, 4'd5, 8'd5},   // three set flags passed
    {16'h00C0, 4'd8, 8'd4},
    {16'hFE00, 4'd2, 8'd11},  // wrap; 0 and 1 marked by earlier selections
    {16'h0008, 4'd4, 8'd3},
    {16'hFFFF, 4'd5, 8'd18},  // every flag set: full sweep
    {16'h0000, 4'd6, 8'd2}
  };

  clock_repl_engine #(.NUM_FRAMES(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .ref_valid (ref_valid),
    .ref_frame (ref_frame),
    .fault_req (fault_req),
    .busy      (busy),
    .done      (done),
    .victim    (victim),
    .hand      (hand)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_refs(input logic [N-1:0] mask);
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        @(negedge clk);
        ref_valid = 1'b1;
        ref_frame = IW'(i);
      end
    end
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic wait_done(inout int cyc);
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_fault(output int cyc);
    @(negedge clk);
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    cyc = 1;
    wait_done(cyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 victim", int'(victim), 0);
    chk("R1 hand", int'(hand), 0);

    // R2 R3 R4 R5 R6 R7: vector table
    for (int v = 0; v < 8; v++) begin
      logic [27:0] e;
      e = VECS[v];
      apply_refs(e[27:12]);
      run_fault(cyc);
      chk("R4 victim", int'(victim), int'(e[11:8]));
      chk("R4 R7 cycles", cyc, int'(e[7:0]));
      chk("R5 hand", int'(hand), (int'(e[11:8]) + 1) % N);
      @(negedge clk);
      chk("R4 done pulse", int'(done), 0);
    end

    // R9: second fault while busy is ignored
    apply_refs(16'h0380);
    @(negedge clk); fault_req = 1'b1;
    @(negedge clk); fault_req = 1'b0; cyc = 1;
    chk("R3 busy", int'(busy), 1);
    @(negedge clk); fault_req = 1'b1; cyc++;
    @(negedge clk); fault_req = 1'b0; cyc++;
    wait_done(cyc);
    chk("R9 victim", int'(victim), 10);
    chk("R9 cycles", cyc, 5);
    @(negedge clk);
    chk("R9 no new sweep", int'(busy), 0);
    @(negedge clk);
    chk("R9 no second done", int'(done), 0);
    chk("R5 hand hold", int'(hand), 11);

    // R8: reference to the frame being cleared at the same edge
    apply_refs(16'h1800);
    @(negedge clk); fault_req = 1'b1;
    @(negedge clk); fault_req = 1'b0; cyc = 1;
    @(negedge clk); ref_valid = 1'b1; ref_frame = 4'd12; cyc++;
    @(negedge clk); ref_valid = 1'b0; cyc++;
    wait_done(cyc);
    chk("R8 victim", int'(victim), 13);
    apply_refs(16'hCB9F);
    run_fault(cyc);
    chk("R8 set wins victim", int'(victim), 14);
    chk("R8 R7 set wins cycles", cyc, 18);

    // R10: reference to another frame during a search
    @(negedge clk); fault_req = 1'b1;
    @(negedge clk); fault_req = 1'b0; ref_valid = 1'b1; ref_frame = 4'd0; cyc = 1;
    @(negedge clk); ref_valid = 1'b0; cyc++;
    wait_done(cyc);
    chk("R10 victim", int'(victim), 15);
    run_fault(cyc);
    chk("R10 ref kept victim", int'(victim), 1);
    chk("R10 ref kept cycles", cyc, 3);

    // R1: reset in the middle of a search
    apply_refs(16'h00FC);
    @(negedge clk); fault_req = 1'b1;
    @(negedge clk); fault_req = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 hand after reset", int'(hand), 0);
    chk("R1 victim after reset", int'(victim), 0);
    run_fault(cyc);
    chk("R1 flags cleared victim", int'(victim), 0);
    chk("R1 flags cleared cycles", cyc, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule